// File: doc/BRIEF.md
# Integer Register File with Deferred-Exception Tags

This block is the general-purpose integer register file of an execution core. It holds 128 registers of 64 bits each. Every register carries one extra tag bit. When set, the tag says the stored value is not valid, because a speculative producer deferred an exception instead of raising it. There are two combinational read ports. Each returns the data and the tag of the register it addresses. One synchronous write port stores data and tag together.

Register 0 is a constant. It reads as a valid zero, and software may never write it. A write request aimed at index 0 is not dropped silently. It changes no state and produces a one-cycle fault pulse on the cycle after the request, which the core's exception logic consumes. A producer that has no valid result asserts the speculative-write input with the write enable. The target register then gets its tag set and its data cleared, whatever the data and tag inputs carry. A write that lands in the same cycle as a read of the same nonzero index is forwarded to the read port, so readers always see the newest value.

Top module: `irf_nat_file`

## Requirements
- R1: On a rising clock edge with `wr_en` high, `wr_spec` low and `wr_idx` nonzero, register `wr_idx` (7-bit index, 0 to 127) takes `wr_data` (64 bits) and `wr_nat` (tag) together; the other registers are unchanged.
- R2: Each read port returns the stored data and tag of the register selected by its index combinationally, with no clock edge in between; the two ports work independently and may select the same register.
- R3: Index 0 always reads as data zero with the tag clear, on both ports, at all times.
- R4: A request with `wr_en` high and `wr_idx` equal to 0 drives `wr_fault` high for exactly the one cycle after the request edge and changes no register; `wr_fault` is low in every other cycle.
- R5: On a rising edge with `wr_en` and `wr_spec` both high and `wr_idx` nonzero, register `wr_idx` gets its tag set to 1 and its data set to zero, whatever `wr_data` and `wr_nat` hold.
- R6: When a read index equals a nonzero `wr_idx` while `wr_en` is high, that port returns the value being written in that cycle (data and tag, with the R5 substitution when `wr_spec` is high) instead of the stored value; index 0 is never forwarded.
- R7: A rising edge with `rst` high clears every register's data and tag to zero and drives `wr_fault` low on the next cycle, whatever the write inputs hold.
- R8: With `wr_en` low, no register changes, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_spec | input | 1 | Speculative write: set tag, clear data |
| wr_idx | input | 7 | Write target index |
| wr_data | input | 64 | Write data |
| wr_nat | input | 1 | Write tag (1 = value not valid) |
| rd0_idx | input | 7 | Read port 0 index |
| rd0_data | output | 64 | Read port 0 data |
| rd0_nat | output | 1 | Read port 0 tag |
| rd1_idx | input | 7 | Read port 1 index |
| rd1_data | output | 64 | Read port 1 data |
| rd1_nat | output | 1 | Read port 1 tag |
| wr_fault | output | 1 | One-cycle pulse after a write request to index 0 |

## Verification
Every nonzero register is written with a value made from its own index, and the tag alternates with the low index bit. A sweep of all 128 indices on both ports, with port 1 walking in the opposite order and also on the same index, then shows that no writes alias and that the ports select independently. Forwarding is checked at each write by reading the target index in the write cycle itself. A speculative pass carries garbage data with the tag input clear, which separates a real tag-and-clear from a plain store. A write to index 0 and a disabled write that carries garbage data are each followed by a full sweep to show nothing changed. A second reset after the file is full shows that every entry clears.

// File: rtl/irf_pkg.sv
package irf_pkg;

    // Classification of the write request in the current cycle
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_NORMAL = 2'd1,
        WR_SPEC   = 2'd2,
        WR_FAULT  = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/irf_wr_decode.sv
module irf_wr_decode
    import irf_pkg::*;
#(
    parameter int NREG = 128,
    parameter int XLEN = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             wr_en,
    input  logic             wr_spec,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             wr_nat,
    output wr_kind_e         kind,
    output logic [XLEN-1:0]  eff_data,
    output logic             eff_nat
);

    always_comb begin
        if (!wr_en) begin
            kind = WR_NONE;
        end else if (wr_idx == '0) begin
            kind = WR_FAULT;
        end else if (wr_spec) begin
            kind = WR_SPEC;
        end else begin
            kind = WR_NORMAL;
        end
        // speculative producers supply no data: tag set, value cleared
        eff_data = wr_spec ? '0 : wr_data;
        eff_nat  = wr_spec | wr_nat;
    end

endmodule

// File: rtl/irf_store.sv
module irf_store
    import irf_pkg::*;
#(
    parameter int NREG = 128,
    parameter int XLEN = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_kind_e                   kind,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [XLEN-1:0]            eff_data,
    input  logic                       eff_nat,
    output logic [NREG-1:0][XLEN-1:0]  data_o,
    output logic [NREG-1:0]            nat_o,
    output logic                       fault_o
);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] data;
        logic [NREG-1:0]           nat;
        logic                      fault;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        unique case (kind)
            WR_NORMAL, WR_SPEC: begin
                st_d.data[wr_idx] = eff_data;
                st_d.nat[wr_idx]  = eff_nat;
            end
            WR_FAULT: st_d.fault = 1'b1;
            default: ;
        endcase
        // entry 0 is a constant valid zero
        st_d.data[0] = '0;
        st_d.nat[0]  = 1'b0;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign nat_o   = st_q.nat;
    assign fault_o = st_q.fault;

    // R4
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fault_o == $past(kind == WR_FAULT)));

    // R4
    fault_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_FAULT) |=> ($stable(data_o) && $stable(nat_o)));

    // R8
    idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_NONE) |=> ($stable(data_o) && $stable(nat_o)));

    // R5
    spec_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_SPEC) |=> (nat_o[$past(wr_idx)] && (data_o[$past(wr_idx)] == '0)));

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((nat_o == '0) && (data_o == '0) && !fault_o));

endmodule

// File: rtl/irf_rd_port.sv
module irf_rd_port
    import irf_pkg::*;
#(
    parameter int NREG = 128,
    parameter int XLEN = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [NREG-1:0][XLEN-1:0]  st_data,
    input  logic [NREG-1:0]            st_nat,
    input  wr_kind_e                   kind,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [XLEN-1:0]            eff_data,
    input  logic                       eff_nat,
    output logic [XLEN-1:0]            rd_data,
    output logic                       rd_nat
);

    logic fwd_hit;

    always_comb begin
        fwd_hit = ((kind == WR_NORMAL) || (kind == WR_SPEC)) && (wr_idx == rd_idx);
        if (rd_idx == '0) begin
            rd_data = '0;
            rd_nat  = 1'b0;
        end else if (fwd_hit) begin
            rd_data = eff_data;
            rd_nat  = eff_nat;
        end else begin
            rd_data = st_data[rd_idx];
            rd_nat  = st_nat[rd_idx];
        end
    end

    // R3
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == '0) |-> ((rd_data == '0) && !rd_nat));

    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        ((kind == WR_NORMAL || kind == WR_SPEC) && (wr_idx == rd_idx))
            |-> ((rd_data == eff_data) && (rd_nat == eff_nat)));

endmodule

// File: rtl/irf_nat_file.sv
module irf_nat_file
    import irf_pkg::*;
#(
    parameter int NREG = 128,
    parameter int XLEN = 64,
    localparam int IDX_W = $clog2(NREG),
    localparam int NRD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_spec,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             wr_nat,
    input  logic [IDX_W-1:0] rd0_idx,
    output logic [XLEN-1:0]  rd0_data,
    output logic             rd0_nat,
    input  logic [IDX_W-1:0] rd1_idx,
    output logic [XLEN-1:0]  rd1_data,
    output logic             rd1_nat,
    output logic             wr_fault
);

    wr_kind_e                  kind;
    logic [XLEN-1:0]           eff_data;
    logic                      eff_nat;
    logic [NREG-1:0][XLEN-1:0] st_data;
    logic [NREG-1:0]           st_nat;

    logic [NRD-1:0][IDX_W-1:0] rd_idx_v;
    logic [NRD-1:0][XLEN-1:0]  rd_data_v;
    logic [NRD-1:0]            rd_nat_v;

    irf_wr_decode #(.NREG(NREG), .XLEN(XLEN)) i_dec (
        .wr_en    (wr_en),
        .wr_spec  (wr_spec),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .wr_nat   (wr_nat),
        .kind     (kind),
        .eff_data (eff_data),
        .eff_nat  (eff_nat)
    );

    irf_store #(.NREG(NREG), .XLEN(XLEN)) i_store (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .wr_idx   (wr_idx),
        .eff_data (eff_data),
        .eff_nat  (eff_nat),
        .data_o   (st_data),
        .nat_o    (st_nat),
        .fault_o  (wr_fault)
    );

    assign rd_idx_v[0] = rd0_idx;
    assign rd_idx_v[1] = rd1_idx;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        irf_rd_port #(.NREG(NREG), .XLEN(XLEN)) i_port (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (rd_idx_v[p]),
            .st_data  (st_data),
            .st_nat   (st_nat),
            .kind     (kind),
            .wr_idx   (wr_idx),
            .eff_data (eff_data),
            .eff_nat  (eff_nat),
            .rd_data  (rd_data_v[p]),
            .rd_nat   (rd_nat_v[p])
        );
    end

    assign rd0_data = rd_data_v[0];
    assign rd0_nat  = rd_nat_v[0];
    assign rd1_data = rd_data_v[1];
    assign rd1_nat  = rd_nat_v[1];

endmodule

// File: tb/test_irf_nat_file.sv
module test_irf_nat_file;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_spec = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_nat = 1'b0;
    logic [6:0]  rd0_idx = '0;
    logic [63:0] rd0_data;
    logic        rd0_nat;
    logic [6:0]  rd1_idx = '0;
    logic [63:0] rd1_data;
    logic        rd1_nat;
    logic        wr_fault;

    int vectors = 0;
    int misses  = 0;

    logic [63:0] exp_d [NREG];
    logic        exp_n [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    irf_nat_file i_irf_nat_file (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_spec(wr_spec), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_nat(wr_nat),
        .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_nat(rd0_nat),
        .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_nat(rd1_nat),
        .wr_fault(wr_fault)
    );

    function automatic logic [63:0] pat(input int i, input int k);
        return (64'h9E37_79B9_7F4A_7C15 * 64'(i + 131 * k)) ^ {57'(k), 7'(i)};
    endfunction

    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < NREG; i++) begin
            exp_d[i] = '0;
            exp_n[i] = 1'b0;
        end
    endtask

    // full sweep of both ports against the model
    task automatic sweep(input string req);
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            rd0_idx = 7'(i);
            rd1_idx = 7'(NREG - 1 - i);
            #1;
            chk(req, {rd0_nat, rd0_data}, {exp_n[i], exp_d[i]});
            chk(req, {rd1_nat, rd1_data}, {exp_n[NREG-1-i], exp_d[NREG-1-i]});
            rd1_idx = 7'(i);
            #1;
            chk({req, "/R2 same index"}, {rd1_nat, rd1_data}, {exp_n[i], exp_d[i]});
        end
    endtask

    // one write cycle, with forwarding and fault checks
    task automatic wr(input int idx, input logic [63:0] d, input logic n,
                      input logic s, input logic en, input string req);
        logic [63:0] ed;
        logic        en_n;
        @(negedge clk);
        wr_en = en; wr_spec = s; wr_idx = 7'(idx); wr_data = d; wr_nat = n;
        rd0_idx = 7'(idx);
        ed   = s ? 64'd0 : d;
        en_n = s | n;
        #1;
        if (idx == 0) begin
            chk("R3/R6 no forward to 0", {rd0_nat, rd0_data}, 65'd0);
        end else if (en) begin
            chk({req, "/R6 forward"}, {rd0_nat, rd0_data}, {en_n, ed});
        end else begin
            chk("R8 no forward when idle", {rd0_nat, rd0_data}, {exp_n[idx], exp_d[idx]});
        end
        @(posedge clk);
        #1;
        if (en && idx != 0) begin
            exp_d[idx] = ed;
            exp_n[idx] = en_n;
        end
        chk("R4 fault level", 65'(wr_fault), 65'(en && idx == 0));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R7 fault after reset", 65'(wr_fault), 65'd0);
        sweep("R7 reset state");

        // R1: fill every nonzero register
        for (int i = 1; i < NREG; i++) begin
            wr(i, pat(i, 1), i[0], 1'b0, 1'b1, "R1");
        end
        sweep("R1/R2 fill");

        // R8: disabled writes with garbage
        for (int i = 0; i < 8; i++) begin
            wr(i * 9 + 3, pat(i, 7), 1'b1, i[0], 1'b0, "R8");
        end
        sweep("R8 idle writes");

        // R4: write to register 0, then back-to-back pair
        wr(0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, "R4");
        wr(0, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b1, 1'b1, "R4");
        wr(0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, 1'b0, 1'b1, "R4");
        wr(5, pat(5, 2), 1'b0, 1'b0, 1'b0, "R4");
        chk("R4 pulse ends", 65'(wr_fault), 65'd0);
        sweep("R4 no change");

        // R5: speculative writes with garbage data and clear tag input
        for (int i = 1; i < NREG; i += 3) begin
            wr(i, pat(i, 3), 1'b0, 1'b1, 1'b1, "R5");
        end
        sweep("R5 spec writes");

        // R1: overwrite spec entries with valid data, tag cleared
        for (int i = 1; i < NREG; i += 6) begin
            wr(i, pat(i, 4), 1'b0, 1'b0, 1'b1, "R1 overwrite");
        end
        sweep("R1 overwrite");

        // R7: reset with write active
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b1; wr_spec = 1'b0; wr_idx = 7'd0; wr_data = '1; wr_nat = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        rst = 1'b0;
        clear_model();
        #1;
        chk("R7 fault cleared", 65'(wr_fault), 65'd0);
        sweep("R7 second reset");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule